// File: doc/BRIEF.md
# DMA Channel Engine with Descriptor Chaining

This engine moves data between memory locations, or between memory and peripherals, on behalf of a set of channels. Each channel holds a source address, a destination address, a link pointer, a control word and a configuration word. The host loads these through a simple register write port. Among the channels that are ready, the engine serves the one with the lowest index. It moves one element, and then it scans all channels again. An element is one read at the source width, followed by one write at the destination width, over a request/acknowledge memory master port.

A configuration word selects a flow type. The flow type decides whether an element waits on the request line of a source peripheral, of a destination peripheral, of both, or of neither. When a channel's element count runs out, the engine does one of two things. If the link pointer is nonzero, it fetches a four-word descriptor from memory and carries on. If the link pointer is zero, it switches the channel off. On completion it can emit a one-cycle terminal-count pulse for that channel. A channel with an unsupported flow type is switched off and flagged with an error pulse.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, mem_req is low, all tc_pulse and err_pulse bits are low, and chan_on is all zero.
- R2: A channel is served only when glob_en is high, its configuration bit 0 (on) is set and its configuration bit 18 (halt) is clear. Otherwise no memory access is made for it.
- R3: The flow type is configuration bits 13:11. The source peripheral number is bits 5:1 and the destination peripheral number is bits 10:6. Flow 0 needs no request. Flow 1 waits for periph_req at the destination number. Flow 2 waits for periph_req at the source number. Flow 3 waits for both.
- R4: When several channels are ready, the lowest index wins. Arbitration is redone after every element, so a lower channel finishes all its elements before a higher one starts.
- R5: Each element reads at the source address with mem_size equal to control bits 20:18. It then writes to the destination address with mem_size equal to control bits 23:21. The written data is the read data with the bytes above the source width forced to zero.
- R6: Control bit 26 set adds 2^(bits 20:18) to the source address after each element. Control bit 27 set adds 2^(bits 23:21) to the destination address. A clear bit leaves that address unchanged.
- R7: The element count is control bits 11:0 and is reduced by one per element. Bits 31:12 are kept, so a count of N gives exactly N writes and one completion.
- R8: On completion with a nonzero link pointer L, the engine issues four 32-bit reads in this order: L+0 loads the source, L+4 the destination, L+12 the control word and L+8 the new link pointer. The channel then continues from the new values.
- R9: On completion with a zero link pointer, the channel's on bit clears and chan_on falls. If control bit 31 was set, a one-cycle tc_pulse is raised for that channel. At most one pulse bit across tc_pulse and err_pulse is high in any cycle.
- R10: A served channel whose flow type is 4 to 7 raises a one-cycle err_pulse and is switched off without any memory access.
- R11: A channel that is served while its count is zero completes at once with no element access. It follows the rules of R8 and R9.
- R12: While mem_req is high and mem_ack is low, mem_req stays high and mem_addr and mem_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en | input | 1 | Global enable for all channels |
| periph_req | input | NREQ (32) | Peripheral request lines |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | CW (3) | Channel selected for the write |
| reg_sel | input | 3 | 0 source, 1 destination, 2 link, 3 control, 4 configuration |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW (32) | Byte address |
| mem_size | output | 3 | log2 of access bytes |
| mem_wdata | output | DW (32) | Write data, right aligned |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW (32) | Read data, right aligned, valid with mem_ack |
| tc_pulse | output | NCH (8) | Per-channel completion pulse |
| err_pulse | output | NCH (8) | Per-channel flow-error pulse |
| chan_on | output | NCH (8) | Live value of each channel's on bit |

## Verification
A wrong channel index or a stale address shows up on the first write. That write lands at an unexpected location or arrives out of order. The write log compares each write address against the computed one, and a second byte-level check compares the data. A miscounted element count, or a descriptor loaded into the wrong field, shows up one completion later. It appears as an extra or missing tc_pulse, a wrong read order on the link fetch, or a chained transfer that writes the wrong destination. Faulty request gating or faulty flow-error handling shows up within a few cycles. Either a memory request appears when none is allowed, or chan_on stays high after a transfer should have ended.

// File: rtl/dma_pkg.sv
package dma_pkg;
    // configuration word fields
    localparam int CFG_ON   = 0;
    localparam int CFG_SID  = 1;
    localparam int CFG_DID  = 6;
    localparam int CFG_FLOW = 11;
    localparam int CFG_HALT = 18;
    // control word fields
    localparam int CTL_CNTW = 12;
    localparam int CTL_SW   = 18;
    localparam int CTL_DW   = 21;
    localparam int CTL_SINC = 26;
    localparam int CTL_DINC = 27;
    localparam int CTL_TC   = 31;
    // descriptor word offsets
    localparam int DSC_SRC  = 0;
    localparam int DSC_DST  = 4;
    localparam int DSC_LNK  = 8;
    localparam int DSC_CTL  = 12;
    // register select codes
    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_DST = 3'd1;
    localparam logic [2:0] SEL_LNK = 3'd2;
    localparam logic [2:0] SEL_CTL = 3'd3;
    localparam logic [2:0] SEL_CFG = 3'd4;

    typedef enum logic [2:0] {
        ST_SCAN = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_LSRC = 3'd3,
        ST_LDST = 3'd4,
        ST_LCTL = 3'd5,
        ST_LLNK = 3'd6
    } eng_st_e;
endpackage

// File: rtl/dma_pick.sv
module dma_pick
    import dma_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NREQ = 32,
    parameter int CW   = 3
) (
    input  logic                  glob_en,
    input  logic [NCH-1:0][31:0]  cfg,
    input  logic [NREQ-1:0]       req,
    output logic                  hit,
    output logic [CW-1:0]         idx,
    output logic                  is_err
);
    logic [31:0]    rq;
    logic [NCH-1:0] elig;

    assign rq = 32'(req);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [2:0] fl;
        logic [4:0] sid, did;
        logic       ok;
        assign fl  = cfg[c][CFG_FLOW +: 3];
        assign sid = cfg[c][CFG_SID +: 5];
        assign did = cfg[c][CFG_DID +: 5];
        always_comb begin
            unique case (fl)
                3'd0:    ok = 1'b1;
                3'd1:    ok = rq[did];
                3'd2:    ok = rq[sid];
                3'd3:    ok = rq[sid] & rq[did];
                default: ok = 1'b1;     // bad flow: serve to flag it
            endcase
        end
        assign elig[c] = glob_en & cfg[c][CFG_ON] & ~cfg[c][CFG_HALT] & ok;
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig[c]) begin
                hit = 1'b1;
                idx = CW'(c);
            end
        end
        is_err = cfg[idx][CFG_FLOW + 2];
    end
endmodule

// File: rtl/dma_step.sv
module dma_step
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [31:0]   ctl,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    output logic [AW-1:0] src_n,
    output logic [AW-1:0] dst_n,
    output logic [31:0]   ctl_n,
    output logic          last,
    output logic [DW-1:0] rmask
);
    logic [2:0]          sw, dw;
    logic [CTL_CNTW-1:0] cnt;
    int                  bits;

    assign sw  = ctl[CTL_SW +: 3];
    assign dw  = ctl[CTL_DW +: 3];
    assign cnt = ctl[CTL_CNTW-1:0];

    assign src_n = ctl[CTL_SINC] ? src + (AW'(1) << sw) : src;
    assign dst_n = ctl[CTL_DINC] ? dst + (AW'(1) << dw) : dst;
    assign ctl_n = {ctl[31:CTL_CNTW], cnt - CTL_CNTW'(1)};
    assign last  = (cnt == CTL_CNTW'(1));

    always_comb begin
        bits = 8 << sw;
        if (bits >= DW) rmask = '1;
        else            rmask = (DW'(1) << bits) - DW'(1);
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NREQ = 32,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glob_en,
    input  logic [NREQ-1:0] periph_req,
    input  logic            reg_we,
    input  logic [CW-1:0]   reg_ch,
    input  logic [2:0]      reg_sel,
    input  logic [31:0]     reg_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [2:0]      mem_size,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic [NCH-1:0]  tc_pulse,
    output logic [NCH-1:0]  err_pulse,
    output logic [NCH-1:0]  chan_on
);
    typedef struct packed {
        eng_st_e                st;
        logic [CW-1:0]          cur;
        logic [NCH-1:0][AW-1:0] src;
        logic [NCH-1:0][AW-1:0] dst;
        logic [NCH-1:0][AW-1:0] lnk;
        logic [NCH-1:0][31:0]   ctl;
        logic [NCH-1:0][31:0]   cfg;
        logic [DW-1:0]          buff;
        logic [NCH-1:0]         tc;
        logic [NCH-1:0]         err;
    } eng_t;

    eng_t q, d;

    logic          pk_hit, pk_err;
    logic [CW-1:0] pk_idx;
    logic [AW-1:0] st_src_n, st_dst_n;
    logic [31:0]   st_ctl_n;
    logic          st_last;
    logic [DW-1:0] st_mask;

    dma_pick #(.NCH(NCH), .NREQ(NREQ), .CW(CW)) i_pick (
        .glob_en (glob_en),
        .cfg     (q.cfg),
        .req     (periph_req),
        .hit     (pk_hit),
        .idx     (pk_idx),
        .is_err  (pk_err)
    );

    dma_step #(.AW(AW), .DW(DW)) i_step (
        .ctl   (q.ctl[q.cur]),
        .src   (q.src[q.cur]),
        .dst   (q.dst[q.cur]),
        .src_n (st_src_n),
        .dst_n (st_dst_n),
        .ctl_n (st_ctl_n),
        .last  (st_last),
        .rmask (st_mask)
    );

    always_comb begin
        logic          fin;
        logic [CW-1:0] fch;
        d      = q;
        d.tc   = '0;
        d.err  = '0;
        fin    = 1'b0;
        fch    = q.cur;
        unique case (q.st)
            ST_SCAN: begin
                if (pk_hit) begin
                    d.cur = pk_idx;
                    fch   = pk_idx;
                    if (pk_err) begin
                        d.err[pk_idx]        = 1'b1;
                        d.cfg[pk_idx][CFG_ON] = 1'b0;
                    end else if (q.ctl[pk_idx][CTL_CNTW-1:0] == '0) begin
                        fin = 1'b1;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            ST_RD: if (mem_ack) begin
                d.buff = mem_rdata & st_mask;
                d.st   = ST_WR;
            end
            ST_WR: if (mem_ack) begin
                d.src[q.cur] = st_src_n;
                d.dst[q.cur] = st_dst_n;
                d.ctl[q.cur] = st_ctl_n;
                if (st_last) fin  = 1'b1;
                else         d.st = ST_SCAN;
            end
            ST_LSRC: if (mem_ack) begin
                d.src[q.cur] = AW'(mem_rdata);
                d.st         = ST_LDST;
            end
            ST_LDST: if (mem_ack) begin
                d.dst[q.cur] = AW'(mem_rdata);
                d.st         = ST_LCTL;
            end
            ST_LCTL: if (mem_ack) begin
                d.ctl[q.cur] = 32'(mem_rdata);
                d.st         = ST_LLNK;
            end
            ST_LLNK: if (mem_ack) begin
                d.lnk[q.cur] = AW'(mem_rdata);
                d.st         = ST_SCAN;
            end
            default: d.st = ST_SCAN;
        endcase

        if (fin) begin
            d.tc[fch] = q.ctl[fch][CTL_TC];
            if (q.lnk[fch] != '0) begin
                d.st = ST_LSRC;
            end else begin
                d.cfg[fch][CFG_ON] = 1'b0;
                d.st               = ST_SCAN;
            end
        end

        if (reg_we) begin
            unique case (reg_sel)
                SEL_SRC: d.src[reg_ch] = AW'(reg_wdata);
                SEL_DST: d.dst[reg_ch] = AW'(reg_wdata);
                SEL_LNK: d.lnk[reg_ch] = AW'(reg_wdata);
                SEL_CTL: d.ctl[reg_ch] = reg_wdata;
                SEL_CFG: d.cfg[reg_ch] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req   = (q.st != ST_SCAN);
        mem_we    = (q.st == ST_WR);
        mem_wdata = q.buff;
        mem_size  = 3'd2;
        mem_addr  = q.lnk[q.cur];
        unique case (q.st)
            ST_RD:   begin
                mem_addr = q.src[q.cur];
                mem_size = q.ctl[q.cur][CTL_SW +: 3];
            end
            ST_WR:   begin
                mem_addr = q.dst[q.cur];
                mem_size = q.ctl[q.cur][CTL_DW +: 3];
            end
            ST_LSRC: mem_addr = q.lnk[q.cur] + AW'(DSC_SRC);
            ST_LDST: mem_addr = q.lnk[q.cur] + AW'(DSC_DST);
            ST_LCTL: mem_addr = q.lnk[q.cur] + AW'(DSC_CTL);
            ST_LLNK: mem_addr = q.lnk[q.cur] + AW'(DSC_LNK);
            default: ;
        endcase
    end

    assign tc_pulse  = q.tc;
    assign err_pulse = q.err;
    for (genvar c = 0; c < NCH; c++) begin : g_on
        assign chan_on[c] = q.cfg[c][CFG_ON];
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))) // R12
        else $error("request dropped or changed before acknowledge");

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && !glob_en) |=> !mem_req) // R2
        else $error("access started while globally disabled");

    AST_BAD_FLOW_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SCAN && pk_hit && pk_err) |=> !mem_req) // R10
        else $error("bad flow type led to a memory access");

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tc_pulse, err_pulse})) // R9
        else $error("more than one pulse in a cycle");
endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
    localparam int NCH = 8;
    localparam int CW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            glob_en = 1'b0;
    logic [31:0]     periph_req = '0;
    logic            reg_we = 1'b0;
    logic [CW-1:0]   reg_ch = '0;
    logic [2:0]      reg_sel = '0;
    logic [31:0]     reg_wdata = '0;
    logic            mem_req, mem_we, mem_ack;
    logic [31:0]     mem_addr, mem_wdata, mem_rdata;
    logic [2:0]      mem_size;
    logic [NCH-1:0]  tc_pulse, err_pulse, chan_on;
    logic            stall = 1'b0;

    int total = 0, bad = 0, cyc = 0;
    int wcnt = 0, rcnt = 0;
    logic [7:0] wlog [16];
    logic [7:0] rlog [16];
    int tc_cnt [NCH];
    int err_cnt [NCH];
    logic [7:0] mem [256];

    always #2 clk = ~clk;   // 250 MHz

    dma_chain_engine i_dma_chain_engine (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .periph_req(periph_req),
        .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tc_pulse(tc_pulse), .err_pulse(err_pulse), .chan_on(chan_on)
    );

    assign mem_ack = mem_req & ~stall;

    always_comb begin
        mem_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < (1 << mem_size)) mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
    end

    // memory model and monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                tc_cnt[c]  += int'(tc_pulse[c]);
                err_cnt[c] += int'(err_pulse[c]);
            end
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    if (wcnt < 16) wlog[wcnt] = mem_addr[7:0];
                    wcnt++;
                    for (int k = 0; k < 4; k++)
                        if (k < (1 << mem_size)) mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
                end else begin
                    if (rcnt < 16) rlog[rcnt] = mem_addr[7:0];
                    rcnt++;
                end
            end
        end
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int ch, input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = CW'(ch); reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] dd,
                        input logic [31:0] l, input logic [31:0] ct, input logic [31:0] cf);
        wr_reg(ch, 3'd0, s); wr_reg(ch, 3'd1, dd); wr_reg(ch, 3'd2, l);
        wr_reg(ch, 3'd3, ct); wr_reg(ch, 3'd4, cf);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        glob_en = 1'b0;
        wcnt = 0; rcnt = 0;
        for (int c = 0; c < NCH; c++) begin tc_cnt[c] = 0; err_cnt[c] = 0; end
    endtask

    task automatic wait_off(input int ch);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!chan_on[ch]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] mkctl(input int cnt, input int sw, input int dw,
                                          input bit si, input bit di, input bit tc);
        return {tc, 3'b0, di, si, 2'b0, 3'(dw), 3'(sw), 6'b0, 12'(cnt)};
    endfunction

    function automatic logic [31:0] mkcfg(input int flow, input int sid, input int did, input bit halt);
        return {13'b0, halt, 4'b0, 3'(flow), 5'(did), 5'(sid), 1'b1};
    endfunction

    function automatic logic [31:0] word_at(input logic [7:0] a);
        return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
    endfunction

    task automatic put_word(input logic [7:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[8'(a + 8'(k))] = v[8*k +: 8];
    endtask

    // {sw, dw, src, dst, expected destination word}
    localparam logic [51:0] VEC [5] = '{
        {2'd2, 2'd2, 8'h04, 8'h80, 32'h07060504},
        {2'd0, 2'd2, 8'h09, 8'h84, 32'h00000009},
        {2'd1, 2'd1, 8'h0A, 8'h88, 32'h00000B0A},
        {2'd2, 2'd0, 8'h14, 8'h8C, 32'h00000014},
        {2'd1, 2'd2, 8'h22, 8'h90, 32'h00002322}
    };

    initial begin
        logic [31:0] a0;
        for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 8'(i) : 8'h00;
        for (int c = 0; c < NCH; c++) begin tc_cnt[c] = 0; err_cnt[c] = 0; end
        repeat (3) @(negedge clk);
        chk(!mem_req && tc_pulse == '0 && err_pulse == '0 && chan_on == '0, "R1 reset outputs",
            {mem_req, tc_pulse, err_pulse, chan_on}, 32'h0);
        rst_n = 1'b1;

        // vector table: single-element copies at mixed widths
        for (int v = 0; v < 5; v++) begin
            logic [1:0] sw, dw;
            logic [7:0] sa, da;
            logic [31:0] ex;
            {sw, dw, sa, da, ex} = VEC[v];
            clear_logs();
            put_word(da, 32'h0);
            prog(0, {24'h0, sa}, {24'h0, da}, 0, mkctl(1, sw, dw, 0, 0, 1), mkcfg(0, 0, 0, 0));
            glob_en = 1'b1;
            wait_off(0);
            chk(word_at(da) == ex, "R5 element data", word_at(da), ex);
            chk(rcnt == 1 && rlog[0] == sa, "R5 read address", {24'h0, rlog[0]}, {24'h0, sa});
        end

        // three elements, both addresses advancing
        clear_logs();
        prog(0, 32'h10, 32'hA0, 0, mkctl(3, 2, 2, 1, 1, 1), mkcfg(0, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(0);
        chk(word_at(8'hA8) == 32'h1B1A1918, "R6 third element", word_at(8'hA8), 32'h1B1A1918);
        chk(wcnt == 3 && wlog[1] == 8'hA4, "R7 write count", wcnt, 3);
        chk(tc_cnt[0] == 1, "R7 single completion", tc_cnt[0], 1);
        chk(chan_on[0] == 1'b0, "R9 channel off", chan_on[0], 0);

        // source advances, destination fixed
        clear_logs();
        prog(0, 32'h30, 32'hB0, 0, mkctl(2, 0, 0, 1, 0, 0), mkcfg(0, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(0);
        chk(mem[8'hB0] == 8'h31 && wlog[1] == 8'hB0, "R6 fixed destination", mem[8'hB0], 8'h31);
        chk(rlog[1] == 8'h31, "R6 source step", rlog[1], 8'h31);
        chk(tc_cnt[0] == 0, "R9 no pulse without bit31", tc_cnt[0], 0);

        // priority: channel 1 before channel 2
        clear_logs();
        prog(2, 32'h00, 32'h80, 0, mkctl(2, 2, 2, 1, 1, 0), mkcfg(0, 0, 0, 0));
        prog(1, 32'h08, 32'h90, 0, mkctl(2, 2, 2, 1, 1, 0), mkcfg(0, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(2);
        chk(wcnt == 4, "R4 total writes", wcnt, 4);
        chk(wlog[0] == 8'h90 && wlog[1] == 8'h94, "R4 low channel first", {wlog[0], wlog[1]}, 16'h9094);
        chk(wlog[2] == 8'h80 && wlog[3] == 8'h84, "R4 high channel after", {wlog[2], wlog[3]}, 16'h8084);

        // descriptor chain
        clear_logs();
        put_word(8'hC0, 32'h40);
        put_word(8'hC4, 32'hD0);
        put_word(8'hC8, 32'h0);
        put_word(8'hCC, mkctl(1, 2, 2, 0, 0, 1));
        prog(0, 32'h50, 32'hE0, 32'hC0, mkctl(1, 2, 2, 0, 0, 1), mkcfg(0, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(0);
        chk(rlog[1] == 8'hC0 && rlog[2] == 8'hC4, "R8 fetch order a", {rlog[1], rlog[2]}, 16'hC0C4);
        chk(rlog[3] == 8'hCC && rlog[4] == 8'hC8, "R8 fetch order b", {rlog[3], rlog[4]}, 16'hCCC8);
        chk(word_at(8'hD0) == 32'h43424140, "R8 chained transfer", word_at(8'hD0), 32'h43424140);
        chk(tc_cnt[0] == 2 && !chan_on[0], "R9 two completions", tc_cnt[0], 2);

        // flow 2: source request
        clear_logs();
        prog(0, 32'h00, 32'hF8, 0, mkctl(1, 0, 0, 0, 0, 0), mkcfg(2, 5, 7, 0));
        glob_en = 1'b1;
        periph_req = 32'h1 << 7;
        repeat (20) @(negedge clk);
        chk(wcnt == 0 && rcnt == 0 && chan_on[0], "R3 flow2 waits", rcnt, 0);
        periph_req = 32'h1 << 5;
        wait_off(0);
        chk(wcnt == 1, "R3 flow2 runs", wcnt, 1);
        // flow 1: destination request
        clear_logs();
        periph_req = 32'h1 << 5;
        prog(0, 32'h00, 32'hF8, 0, mkctl(1, 0, 0, 0, 0, 0), mkcfg(1, 5, 7, 0));
        glob_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(rcnt == 0 && chan_on[0], "R3 flow1 waits", rcnt, 0);
        periph_req = 32'h1 << 7;
        wait_off(0);
        chk(wcnt == 1, "R3 flow1 runs", wcnt, 1);
        // flow 3: both
        clear_logs();
        periph_req = 32'h1 << 3;
        prog(0, 32'h00, 32'hF8, 0, mkctl(1, 0, 0, 0, 0, 0), mkcfg(3, 3, 4, 0));
        glob_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(rcnt == 0 && chan_on[0], "R3 flow3 waits", rcnt, 0);
        periph_req = (32'h1 << 3) | (32'h1 << 4);
        wait_off(0);
        chk(wcnt == 1, "R3 flow3 runs", wcnt, 1);
        periph_req = '0;

        // global enable and halt
        clear_logs();
        prog(0, 32'h00, 32'hF8, 0, mkctl(1, 0, 0, 0, 0, 0), mkcfg(0, 0, 0, 1));
        repeat (10) @(negedge clk);
        chk(rcnt == 0, "R2 global off", rcnt, 0);
        glob_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(rcnt == 0 && chan_on[0], "R2 halted", rcnt, 0);
        wr_reg(0, 3'd4, mkcfg(0, 0, 0, 0));
        wait_off(0);
        chk(wcnt == 1, "R2 released", wcnt, 1);

        // bad flow type
        clear_logs();
        prog(3, 32'h00, 32'hF8, 0, mkctl(1, 0, 0, 0, 0, 1), mkcfg(5, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(3);
        chk(err_cnt[3] == 1 && !chan_on[3], "R10 error pulse", err_cnt[3], 1);
        chk(rcnt == 0 && wcnt == 0 && tc_cnt[3] == 0, "R10 no access", rcnt + wcnt, 0);

        // zero count
        clear_logs();
        prog(4, 32'h00, 32'hF8, 0, mkctl(0, 0, 0, 0, 0, 1), mkcfg(0, 0, 0, 0));
        glob_en = 1'b1;
        wait_off(4);
        chk(tc_cnt[4] == 1 && !chan_on[4], "R11 immediate completion", tc_cnt[4], 1);
        chk(rcnt == 0 && wcnt == 0, "R11 no element", rcnt + wcnt, 0);

        // stalled memory
        clear_logs();
        put_word(8'hF0, 32'h0);
        prog(0, 32'h60, 32'hF0, 0, mkctl(1, 2, 2, 0, 0, 0), mkcfg(0, 0, 0, 0));
        stall = 1'b1;
        glob_en = 1'b1;
        repeat (2) @(negedge clk);
        a0 = mem_addr;
        repeat (3) @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == a0 && a0 == 32'h60, "R12 held request", mem_addr, 32'h60);
        stall = 1'b0;
        wait_off(0);
        chk(word_at(8'hF0) == 32'h63626160, "R12 data after stall", word_at(8'hF0), 32'h63626160);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule